// File: doc/BRIEF.md
# External Memory Bus Bridge with Programmable Wait States

This block turns single requests from an internal request port into cycles on an asynchronous SRAM/ROM-style bus. The bus has a 20-bit word address, a 32-bit bidirectional data bus, four active-low chip selects, four active-low byte write strobes and one active-low read strobe. Each request carries its own wait-state count of 0 to 3. Zero is the normal setting. A read keeps the read strobe low for 1 + wait clocks. A write takes 3 + wait clocks: one setup clock, 1 + wait strobe clocks and one hold clock.

Two extra bits above the word address select the chip select. An active-high bus-enable input gates the whole external interface. While it is low, external requests complete with an error and the bus stays quiet. A program-area input chooses where instruction fetches go. When it is low, fetches are handed to internal memory and the response only says so. When it is high, fetches run as ordinary external reads.

Top module: `xbus_bridge`

## Requirements
- R1: After reset, all chip selects, byte write strobes and the read strobe are high (inactive), `req_ready` is 1, `rsp_valid` is 0 and the bridge does not drive the data bus.
- R2: An accepted external read holds `bus_oe_n` and one chip select low for exactly 1 + W consecutive clocks, where W is `req_wait` sampled at acceptance. `rsp_valid` pulses for one clock in the next cycle, and `rsp_rdata` carries the bus data present in the last strobe clock.
- R3: An accepted write holds one chip select low for 3 + W clocks. The byte strobes are low for the middle 1 + W clocks, so there is one clock with the chip select low before the strobes fall and one after they rise. `rsp_valid` pulses in the clock after the chip select rises.
- R4: During the strobe clocks, `bus_we_n[i]` is low only when `req_be[i]` was 1, and lane i is data bits [8i+7:8i]. Bytes whose enable is 0 stay unchanged in the memory.
- R5: `req_addr[21:20]` = k selects `bus_cs_n[k]`. `bus_addr` equals `req_addr[19:0]`. No strobe is ever low without a chip select.
- R6: `bus_addr` and `bus_cs_n` stay constant for the whole access. After the access, `bus_addr` keeps its value until the next external access starts.
- R7: The bridge drives `bus_data` only from the setup clock through the hold clock of a write, with the write data, and never while `bus_oe_n` is low.
- R8: While `bus_en` is 0, an accepted external request (read, write, or fetch with `prog_ext` = 1) returns `rsp_valid` with `rsp_err` = 1 in the next clock. It leaves all chip selects high and does not change memory.
- R9: A fetch (`req_fetch` = 1) with `prog_ext` = 0 returns `rsp_valid` with `rsp_local` = 1 in the next clock, with no bus activity, whatever `bus_en` is. With `prog_ext` = 1, a fetch runs as an external read.
- R10: `req_ready` is 0 in every clock in which a chip select is low.
- R11: At most one chip select is low at a time, and the read strobe and any write strobe are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | External bus enable, active high |
| prog_ext | input | 1 | Fetch area select: 0 internal, 1 external |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Request is an instruction fetch (read) |
| req_addr | input | 22 | [21:20] chip select number, [19:0] word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for writes |
| req_wait | input | 2 | Wait states for this access |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Request refused because the bus is disabled |
| rsp_local | output | 1 | Fetch routed to internal memory |
| rsp_rdata | output | 32 | Read data |
| bus_addr | output | 20 | External word address |
| bus_data | inout | 32 | External data bus |
| bus_cs_n | output | 4 | Chip selects, active low |
| bus_we_n | output | 4 | Byte write strobes, active low |
| bus_oe_n | output | 1 | Read strobe, active low |

## Verification
A wrong wait counter shows up in the same access as a strobe that is one or more clocks too short or too long. It also moves the `rsp_valid` pulse and can make a read return data from the wrong clock. A wrong sequencer state shows up within a clock in one of three ways: a write strobe with no setup or hold clock around it, a chip select that changes in the middle of an access, or `req_ready` high during a bus cycle. A wrong choice between local, error and external requests shows up in the clock after acceptance, either as bus activity that should not happen or as the wrong response flag. A wrong byte lane only becomes visible when the word is read back, so each partial write is followed by a read.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WSET,
        ST_WSTB,
        ST_WHOLD
    } xbus_state_e;

    typedef enum logic [1:0] {
        K_LOCAL,
        K_ERR,
        K_RD,
        K_WR
    } xbus_kind_e;

    // Local fetches take priority; then the enable gate; fetches are always reads.
    function automatic xbus_kind_e classify(input logic wr, input logic fetch,
                                            input logic prog_ext, input logic bus_en);
        if (fetch && !prog_ext)
            return K_LOCAL;
        if (!bus_en)
            return K_ERR;
        return (wr && !fetch) ? K_WR : K_RD;
    endfunction

endpackage

// File: rtl/xbus_route.sv
module xbus_route
    import xbus_pkg::*;
(
    input  logic       wr,
    input  logic       fetch,
    input  logic       prog_ext,
    input  logic       bus_en,
    output xbus_kind_e kind
);
    always_comb kind = classify(wr, fetch, prog_ext, bus_en);
endmodule

// File: rtl/xbus_cs_decode.sv
module xbus_cs_decode #(
    parameter int CS_W = 2,
    localparam int NCS = 1 << CS_W
) (
    input  logic [CS_W-1:0] sel,
    input  logic            en,
    output logic [NCS-1:0]  cs_n
);
    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign cs_n[i] = !(en && (sel == CS_W'(i)));
    end
endmodule

// File: rtl/xbus_wait_cnt.sv
module xbus_wait_cnt #(
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              dec,
    output logic              zero
);
    logic [WAIT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/xbus_bridge.sv
module xbus_bridge
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32,
    parameter int CS_W   = 2,
    parameter int WAIT_W = 2,
    localparam int NCS    = 1 << CS_W,
    localparam int BE_W   = DATA_W / 8,
    localparam int REQ_AW = ADDR_W + CS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              prog_ext,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_fetch,
    input  logic [REQ_AW-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    input  logic [WAIT_W-1:0] req_wait,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic              rsp_local,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    inout  wire  [DATA_W-1:0] bus_data,
    output logic [NCS-1:0]    bus_cs_n,
    output logic [BE_W-1:0]   bus_we_n,
    output logic              bus_oe_n
);

    typedef struct packed {
        logic [CS_W-1:0]   sel;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [BE_W-1:0]   be;
    } access_t;

    xbus_state_e state;
    access_t     acc_q;
    xbus_kind_e  kind;
    logic        cs_on, oe_on, we_on, drv_en;
    logic        accept, wait_zero, wait_dec;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign wait_dec  = (state == ST_RD) || (state == ST_WSTB);

    xbus_route u_route (
        .wr       (req_write),
        .fetch    (req_fetch),
        .prog_ext (prog_ext),
        .bus_en   (bus_en),
        .kind     (kind)
    );

    xbus_wait_cnt #(.WAIT_W(WAIT_W)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (req_wait),
        .dec      (wait_dec),
        .zero     (wait_zero)
    );

    xbus_cs_decode #(.CS_W(CS_W)) u_cs (
        .sel  (acc_q.sel),
        .en   (cs_on),
        .cs_n (bus_cs_n)
    );

    assign bus_addr = acc_q.addr;
    assign bus_we_n = ~(acc_q.be & {BE_W{we_on}});
    assign bus_oe_n = ~oe_on;
    assign bus_data = drv_en ? acc_q.wdata : {DATA_W{1'bz}};

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            acc_q     <= '0;
            cs_on     <= 1'b0;
            oe_on     <= 1'b0;
            we_on     <= 1'b0;
            drv_en    <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_local <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_local <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        unique case (kind)
                            K_LOCAL: begin
                                rsp_valid <= 1'b1;
                                rsp_local <= 1'b1;
                            end
                            K_ERR: begin
                                rsp_valid <= 1'b1;
                                rsp_err   <= 1'b1;
                            end
                            K_RD: begin
                                acc_q.sel  <= req_addr[REQ_AW-1:ADDR_W];
                                acc_q.addr <= req_addr[ADDR_W-1:0];
                                cs_on      <= 1'b1;
                                oe_on      <= 1'b1;
                                state      <= ST_RD;
                            end
                            K_WR: begin
                                acc_q.sel   <= req_addr[REQ_AW-1:ADDR_W];
                                acc_q.addr  <= req_addr[ADDR_W-1:0];
                                acc_q.wdata <= req_wdata;
                                acc_q.be    <= req_be;
                                cs_on       <= 1'b1;
                                drv_en      <= 1'b1;
                                state       <= ST_WSET;
                            end
                        endcase
                    end
                end
                ST_RD: begin
                    if (wait_zero) begin
                        rsp_rdata <= bus_data;
                        rsp_valid <= 1'b1;
                        cs_on     <= 1'b0;
                        oe_on     <= 1'b0;
                        state     <= ST_IDLE;
                    end
                end
                ST_WSET: begin
                    we_on <= 1'b1;
                    state <= ST_WSTB;
                end
                ST_WSTB: begin
                    if (wait_zero) begin
                        we_on <= 1'b0;
                        state <= ST_WHOLD;
                    end
                end
                ST_WHOLD: begin
                    cs_on     <= 1'b0;
                    drv_en    <= 1'b0;
                    rsp_valid <= 1'b1;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xbus_bridge_chk.sv
module xbus_bridge_chk #(
    parameter int ADDR_W = 20,
    parameter int NCS    = 4,
    parameter int BE_W   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_en,
    input logic              prog_ext,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_fetch,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              rsp_local,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NCS-1:0]    bus_cs_n,
    input logic [BE_W-1:0]   bus_we_n,
    input logic              bus_oe_n,
    input logic              drv_en
);
    logic cs_any, we_any;
    assign cs_any = (bus_cs_n != '1);
    assign we_any = (bus_we_n != '1);

    assert_one_cs_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~bus_cs_n));

    assert_no_strobe_overlap_R11: assert property (@(posedge clk) disable iff (rst)
        !(!bus_oe_n && we_any));

    assert_strobe_in_cs_R5: assert property (@(posedge clk) disable iff (rst)
        (!bus_oe_n || we_any) |-> cs_any);

    assert_addr_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (cs_any && $past(cs_any)) |-> ($stable(bus_addr) && $stable(bus_cs_n)));

    assert_we_setup_R3: assert property (@(posedge clk) disable iff (rst)
        (we_any && !$past(we_any)) |-> $past(cs_any));

    assert_we_hold_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(we_any) && !we_any) |-> cs_any);

    assert_drive_R7: assert property (@(posedge clk) disable iff (rst)
        drv_en |-> (bus_oe_n && cs_any));

    assert_bus_off_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !bus_en && !(req_fetch && !prog_ext))
        |=> (rsp_valid && rsp_err && !cs_any));

    assert_local_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_fetch && !prog_ext)
        |=> (rsp_valid && rsp_local && !cs_any));

    assert_busy_R10: assert property (@(posedge clk) disable iff (rst)
        cs_any |-> !req_ready);

endmodule

bind xbus_bridge xbus_bridge_chk #(
    .ADDR_W (ADDR_W),
    .NCS    (NCS),
    .BE_W   (BE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .prog_ext  (prog_ext),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_fetch (req_fetch),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_local (rsp_local),
    .bus_addr  (bus_addr),
    .bus_cs_n  (bus_cs_n),
    .bus_we_n  (bus_we_n),
    .bus_oe_n  (bus_oe_n),
    .drv_en    (drv_en)
);

// File: tb/tb_xbus_bridge.sv
`timescale 1ns/1ps
module tb_xbus_bridge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b1;
    logic        prog_ext = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_fetch = 1'b0;
    logic [21:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic [1:0]  req_wait = '0;
    logic        rsp_valid, rsp_err, rsp_local;
    logic [31:0] rsp_rdata;
    logic [19:0] bus_addr;
    wire  [31:0] bus_data;
    logic [3:0]  bus_cs_n;
    logic [3:0]  bus_we_n;
    logic        bus_oe_n;

    always #10 clk = ~clk;

    xbus_bridge dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .prog_ext(prog_ext),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_fetch(req_fetch), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .req_wait(req_wait), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_local(rsp_local), .rsp_rdata(rsp_rdata),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_cs_n(bus_cs_n),
        .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n)
    );

    // Memory model: 4 banks of 16 words, indexed by bus_addr[3:0]
    logic [31:0] mem [4][16];
    logic [31:0] shadow [4][16];
    logic [31:0] mem_rd;

    function automatic int bank_of(input logic [3:0] cs_n);
        for (int i = 0; i < 4; i++) if (!cs_n[i]) return i;
        return 0;
    endfunction

    always_comb mem_rd = mem[bank_of(bus_cs_n)][bus_addr[3:0]];
    assign bus_data = !bus_oe_n ? mem_rd : 32'bz;

    always @(posedge clk) begin
        if (bus_cs_n != 4'hF) begin
            for (int l = 0; l < 4; l++)
                if (!bus_we_n[l])
                    mem[bank_of(bus_cs_n)][bus_addr[3:0]][8*l +: 8] <= bus_data[8*l +: 8];
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 60000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // Observations of the last access
    int          o_n, o_cs, o_oe, o_we, o_wfirst, o_wlast, o_bank, o_busyrdy, o_overlap, o_multi;
    logic [19:0] o_addr;
    logic [31:0] o_setup;
    logic [3:0]  o_wepat;
    logic        o_err, o_local, o_done;
    logic [31:0] o_rdata;

    task automatic access(input logic wr, input logic fetch, input logic [21:0] a,
                          input logic [31:0] d, input logic [3:0] be, input logic [1:0] w);
        @(negedge clk);
        req_write = wr; req_fetch = fetch; req_addr = a; req_wdata = d;
        req_be = be; req_wait = w; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        o_n = 0; o_cs = 0; o_oe = 0; o_we = 0; o_wfirst = -1; o_wlast = -1;
        o_bank = -1; o_busyrdy = 0; o_overlap = 0; o_multi = 0;
        o_addr = '0; o_setup = '0; o_wepat = 4'hF; o_done = 1'b0;
        o_err = 1'b0; o_local = 1'b0; o_rdata = '0;
        for (int k = 0; k < 20; k++) begin
            if (rsp_valid) begin
                o_err = rsp_err; o_local = rsp_local; o_rdata = rsp_rdata; o_done = 1'b1;
                break;
            end
            o_n++;
            if (bus_cs_n != 4'hF) begin
                o_cs++;
                if (o_cs == 1) begin
                    o_addr = bus_addr;
                    o_bank = bank_of(bus_cs_n);
                    if (wr && !fetch) o_setup = bus_data;
                end
                if ($countones(~bus_cs_n) > 1) o_multi++;
                if (req_ready) o_busyrdy++;
            end
            if (!bus_oe_n) o_oe++;
            if (bus_we_n != 4'hF) begin
                o_we++; o_wepat = bus_we_n;
                if (o_wfirst < 0) o_wfirst = k;
                o_wlast = k;
                if (!bus_oe_n) o_overlap++;
            end
            @(negedge clk);
        end
        chk(o_done, "R2/R3 response arrives", 32'(o_done), 1);
        chk(o_busyrdy == 0, "R10 ready low while busy", o_busyrdy, 0);
        chk(o_overlap == 0 && o_multi == 0, "R11 strobe/select exclusion", o_overlap + o_multi, 0);
    endtask

    task automatic do_write(input logic [21:0] a, input logic [31:0] d,
                            input logic [3:0] be, input logic [1:0] w);
        int b;
        b = int'(a[21:20]);
        access(1'b1, 1'b0, a, d, be, w);
        chk(o_cs == 3 + w, "R3 chip select length", o_cs, 3 + w);
        chk(o_we == 1 + w && o_wfirst == 1 && o_wlast == 1 + w, "R3 strobe window",
            {8'(o_wfirst), 8'(o_wlast), 16'(o_we)}, {8'd1, 8'(1 + w), 16'(1 + w)});
        chk(o_oe == 0 && !o_err, "R3 no read strobe in write", o_oe, 0);
        chk(o_bank == b && o_addr == a[19:0], "R5 select and address",
            {12'(o_bank), o_addr}, {12'(b), a[19:0]});
        chk(o_setup == d, "R7 write data driven in setup", o_setup, d);
        chk(o_wepat == ~be, "R4 byte strobe pattern", o_wepat, ~be);
        for (int l = 0; l < 4; l++)
            if (be[l]) shadow[b][a[3:0]][8*l +: 8] = d[8*l +: 8];
    endtask

    task automatic do_read(input logic [21:0] a, input logic [1:0] w, input string tag);
        int b;
        b = int'(a[21:20]);
        access(1'b0, 1'b0, a, '0, '0, w);
        chk(o_cs == 1 + w && o_oe == 1 + w && o_we == 0, "R2 read strobe length", o_oe, 1 + w);
        chk(o_n == 1 + w, "R2 response one clock after strobe", o_n, 1 + w);
        chk(o_bank == b && o_addr == a[19:0], "R5 read select and address",
            {12'(o_bank), o_addr}, {12'(b), a[19:0]});
        chk(o_rdata == shadow[b][a[3:0]], tag, o_rdata, shadow[b][a[3:0]]);
    endtask

    task automatic t_reset;
        chk(bus_cs_n == 4'hF && bus_we_n == 4'hF && bus_oe_n, "R1 strobes idle after reset",
            {bus_cs_n, bus_we_n, 3'b0, bus_oe_n}, 32'h0000_0FF1);
        chk(req_ready && !rsp_valid, "R1 ready and no response", {req_ready, rsp_valid}, 2'b10);
        chk(bus_addr == '0, "R1 address cleared", bus_addr, 0);
    endtask

    task automatic t_timing;
        for (int w = 0; w < 4; w++)
            do_write({2'(w), 16'hA5C3, 4'(w + 1)}, 32'hC0DE_0000 + 32'(w * 32'h1111), 4'hF, 2'(w));
        for (int w = 0; w < 4; w++)
            do_read({2'(w), 16'hA5C3, 4'(w + 1)}, 2'(3 - w), "R2 read data");
    endtask

    task automatic t_lanes;
        do_write({2'd1, 16'h0000, 4'd9}, 32'hFFFF_FFFF, 4'hF, 2'd0);
        do_write({2'd1, 16'h0000, 4'd9}, 32'h1234_5678, 4'b0101, 2'd1);
        do_read({2'd1, 16'h0000, 4'd9}, 2'd0, "R4 merged bytes");
        chk(shadow[1][9] == 32'hFF34_FF78, "R4 expected merge", shadow[1][9], 32'hFF34_FF78);
        do_write({2'd3, 16'h1234, 4'd2}, 32'hAABB_CCDD, 4'b1000, 2'd2);
        do_read({2'd3, 16'h1234, 4'd2}, 2'd1, "R4 single top byte");
    endtask

    task automatic t_hold;
        do_read({2'd2, 16'hBEEF, 4'd3}, 2'd2, "R6 read");
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(bus_addr == 20'hBEEF3 && bus_cs_n == 4'hF, "R6 address held after access",
                bus_addr, 20'hBEEF3);
        end
    endtask

    task automatic t_bus_off;
        bus_en = 1'b0;
        access(1'b0, 1'b0, {2'd0, 16'h0, 4'd1}, '0, '0, 2'd0);
        chk(o_err && o_cs == 0 && o_n == 0, "R8 read refused", {o_err, 8'(o_cs)}, 9'h100);
        access(1'b1, 1'b0, {2'd2, 16'h0, 4'd5}, 32'hDEAD_BEEF, 4'hF, 2'd0);
        chk(o_err && o_cs == 0 && o_we == 0, "R8 write refused", {o_err, 8'(o_cs)}, 9'h100);
        access(1'b0, 1'b1, {2'd0, 16'h0, 4'd1}, '0, '0, 2'd0);
        chk(o_err && !o_local && o_cs == 0, "R8 external fetch refused", {o_err, o_local}, 2'b10);
        bus_en = 1'b1;
        do_read({2'd2, 16'h0, 4'd5}, 2'd0, "R8 memory untouched");
    endtask

    task automatic t_fetch;
        prog_ext = 1'b0;
        access(1'b0, 1'b1, {2'd0, 16'hA5C3, 4'd1}, '0, '0, 2'd3);
        chk(o_local && !o_err && o_cs == 0 && o_n == 0, "R9 internal fetch", {o_local, o_err}, 2'b10);
        bus_en = 1'b0;
        access(1'b0, 1'b1, {2'd0, 16'hA5C3, 4'd1}, '0, '0, 2'd0);
        chk(o_local && !o_err && o_cs == 0, "R9 internal fetch with bus off", {o_local, o_err}, 2'b10);
        bus_en = 1'b1;
        prog_ext = 1'b1;
        access(1'b0, 1'b1, {2'd0, 16'hA5C3, 4'd1}, '0, '0, 2'd1);
        chk(!o_local && o_oe == 2 && o_rdata == shadow[0][1], "R9 external fetch",
            o_rdata, shadow[0][1]);
    endtask

    initial begin
        for (int b = 0; b < 4; b++)
            for (int i = 0; i < 16; i++) begin
                mem[b][i] = 32'(b * 16 + i) ^ 32'h5A5A_0000;
                shadow[b][i] = 32'(b * 16 + i) ^ 32'h5A5A_0000;
            end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_timing();
        t_lanes();
        t_hold();
        t_bus_off();
        t_fetch();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule